// File: doc/BRIEF.md
# Mode-Switchable Systolic Matrix Multiplier

This block is a square grid of `DIM` x `DIM` multiply-accumulate cells that computes one `DIM` x `DIM` tile of the product C = A x B. The operands are signed 8-bit integers and the sums are 32-bit. Before each tile, a mode code picks one of three dataflows. In the weight-stationary flow, every cell keeps one element of B, activations travel downward and partial sums travel east. In the input-stationary flow, every cell keeps one element of A, weights travel east and partial sums travel downward. In the output-stationary flow, every cell builds its own element of C in place while A moves east and B moves down. After the tile, the finished sums are shifted down and out of the grid.

Every cell has one extra 8-bit holding register. In the two fixed-operand flows, a short preload of `DIM` beats fills these registers before the operand streams start. The caller supplies the streams already skewed, with lane n delayed by n cycles. The block returns its results on per-lane outputs, each lane with its own valid bit, and raises a one-cycle done pulse when the tile is complete. All timing is counted from the first cycle in which any stream valid is seen.

Top module: `flexflow_array`

## Requirements
- R1: While the synchronous reset is high, and on the cycle after it, every bit of `res_vld` is 0 and `done` is 0.
- R2: Mode code 0 selects the weight-stationary flow. The cell in row r, column c holds B[c][r]. North lane c carries A[i][c] in cycle i+c. Result lane r then carries C[i][r], with its valid bit set, in cycle i+DIM+r.
- R3: Mode code 1 selects the input-stationary flow. The cell in row r, column c holds A[c][r]. West lane r carries B[r][j] in cycle j+r. Result lane c then carries C[c][j], with its valid bit set, in cycle j+DIM+c.
- R4: Mode code 2 selects the output-stationary flow. West lane r carries A[r][k] in cycle k+r, and north lane c carries B[k][c] in cycle k+c. In cycles 3*DIM-2+d, for d from 0 to DIM-1, all result lanes are valid together and lane c carries C[DIM-1-d][c].
- R5: `done` is high for exactly one cycle. That cycle is 3*DIM-1 in modes 0 and 1, and 4*DIM-2 in mode 2.
- R6: A `start` pulse that arrives while a tile is in progress is ignored, together with the mode code it carries, so the tile's results and its done cycle do not change.
- R7: A `start` with mode code 3 is ignored: the block stays idle and accepts the next valid `start`.
- R8: Products are exact signed 8x8 multiplications, and sums are exact signed 32-bit accumulations, including when every operand is -128.
- R9: Modes 0 and 1 take `DIM` preload beats, marked by `pre_vld`. Beat b on lane c loads the cell in row DIM-1-b, column c. Streaming starts only after the last beat.
- R10: Stream valids presented while no tile is in its streaming phase produce no result valids.
- R11: Each accepted `start` clears every accumulator, so an output-stationary tile that directly follows a tile in another mode is exact.
- R12: Cycle 0 of the schedule is the first cycle after the preload, or after the `start` in mode 2, in which any stream valid is high. Idle cycles before it do not shift any result.
- R13: A reset during a tile returns the block to idle with no valids, and the next tile runs normally.

Lanes are packed with lane n at bits [n*W +: W], where W is the field width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Starts a tile when the block is idle |
| mode_sel | input | 2 | Dataflow code: 0 weight-, 1 input-, 2 output-stationary |
| pre_vld | input | 1 | Preload beat valid |
| pre_data | input | DIM*DATA_W | One holding-register value per column |
| west_vld | input | DIM | Per-row stream valid |
| west_data | input | DIM*DATA_W | Per-row operand stream entering from the west |
| north_vld | input | DIM | Per-column stream valid |
| north_data | input | DIM*DATA_W | Per-column operand stream entering from the north |
| res_vld | output | DIM | Per-lane result valid |
| res_data | output | DIM*ACC_W | Per-lane signed result |
| done | output | 1 | One-cycle tile-complete pulse |

## Verification
In the two fixed-operand modes, each result is due DIM+L cycles after the operand index that produced it, where L is the output lane. The last of these results falls in cycle 3*DIM-2 and `done` follows one cycle later. In the output-stationary mode, the drained rows appear in cycles 3*DIM-2 to 4*DIM-3 in descending row order, and `done` comes in cycle 4*DIM-2. The bench counts cycles from the first valid stream beat. At the falling edge of every cycle up to the done cycle, it samples the whole valid vector, every valid lane's value and `done`, and compares them with the values these formulas predict for that cycle. Each cycle is therefore matched exactly rather than only in order.

// File: rtl/flexflow_pkg.sv
package flexflow_pkg;

   typedef enum logic [1:0] {
      FLOW_WS = 2'd0,
      FLOW_IS = 2'd1,
      FLOW_OS = 2'd2
   } flow_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOAD,
      ST_RUN,
      ST_DRAIN,
      ST_DONE
   } ctl_state_e;

endpackage

// File: rtl/flexflow_pe.sv
module flexflow_pe
   import flexflow_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ACC_W  = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  flow_e             flow,
   input  logic              clr,
   input  logic              load_en,
   input  logic              drain_en,
   input  logic [DATA_W-1:0] h_in,
   input  logic              h_vld_in,
   output logic [DATA_W-1:0] h_out,
   output logic              h_vld_out,
   input  logic [DATA_W-1:0] v_in,
   input  logic              v_vld_in,
   output logic [DATA_W-1:0] v_out,
   output logic              v_vld_out,
   input  logic [DATA_W-1:0] stat_in,
   output logic [DATA_W-1:0] stat_out,
   input  logic [ACC_W-1:0]  ps_in,
   output logic [ACC_W-1:0]  ps_out,
   output logic              ps_vld_out
);

   localparam int PROD_W = 2 * DATA_W;

   logic [DATA_W-1:0]        h_q, v_q, stat_q;
   logic                     h_vld_q, v_vld_q, ps_vld_q;
   logic [ACC_W-1:0]         ps_q, ps_nx, prod_ext;
   logic                     pv_nx;
   logic signed [DATA_W-1:0] op_a, op_b;
   logic signed [PROD_W-1:0] prod;

   // operand selection follows the latched dataflow
   always_comb begin
      unique case (flow)
         FLOW_WS: begin op_a = v_in; op_b = stat_q; end
         FLOW_IS: begin op_a = h_in; op_b = stat_q; end
         default: begin op_a = h_in; op_b = v_in;   end
      endcase
   end

   assign prod     = op_a * op_b;
   assign prod_ext = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};

   always_comb begin
      ps_nx = ps_q;
      pv_nx = 1'b0;
      unique case (flow)
         FLOW_WS: begin
            ps_nx = ps_in + (v_vld_in ? prod_ext : '0);
            pv_nx = v_vld_in;
         end
         FLOW_IS: begin
            ps_nx = ps_in + (h_vld_in ? prod_ext : '0);
            pv_nx = h_vld_in;
         end
         default: begin
            if (drain_en)
               ps_nx = ps_in;
            else if (h_vld_in && v_vld_in)
               ps_nx = ps_q + prod_ext;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         h_q      <= '0;
         h_vld_q  <= 1'b0;
         v_q      <= '0;
         v_vld_q  <= 1'b0;
         stat_q   <= '0;
         ps_q     <= '0;
         ps_vld_q <= 1'b0;
      end else begin
         h_q     <= h_in;
         h_vld_q <= h_vld_in;
         v_q     <= v_in;
         v_vld_q <= v_vld_in;
         if (load_en)
            stat_q <= stat_in;
         if (clr) begin
            ps_q     <= '0;
            ps_vld_q <= 1'b0;
         end else begin
            ps_q     <= ps_nx;
            ps_vld_q <= pv_nx;
         end
      end
   end

   assign h_out      = h_q;
   assign h_vld_out  = h_vld_q;
   assign v_out      = v_q;
   assign v_vld_out  = v_vld_q;
   assign stat_out   = stat_q;
   assign ps_out     = ps_q;
   assign ps_vld_out = ps_vld_q;

endmodule

// File: rtl/flexflow_ctl.sv
module flexflow_ctl
   import flexflow_pkg::*;
#(
   parameter int DIM = 4
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       start,
   input  logic [1:0] mode_sel,
   input  logic       pre_vld,
   input  logic       any_vld,
   output flow_e      flow,
   output logic       clr,
   output logic       load_en,
   output logic       run_en,
   output logic       drain_en,
   output logic       done,
   output logic       idle
);

   localparam int CNT_W  = $clog2(4 * DIM + 1);
   localparam int T_FIX  = 3 * DIM - 2;   // last result cycle, fixed-operand flows
   localparam int T_OUT  = 3 * DIM - 3;   // last accumulate cycle, output flow

   ctl_state_e       st_q;
   flow_e            flow_q;
   logic [CNT_W-1:0] cnt_q, cur_t, last_t;
   logic             seen_q, accept, tick;

   assign accept = (st_q == ST_IDLE) && start && (mode_sel != 2'd3);
   assign cur_t  = seen_q ? cnt_q : '0;
   assign tick   = (st_q == ST_RUN) && (seen_q || any_vld);
   assign last_t = (flow_q == FLOW_OS) ? CNT_W'(T_OUT) : CNT_W'(T_FIX);

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= ST_IDLE;
         flow_q <= FLOW_WS;
         cnt_q  <= '0;
         seen_q <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (accept) begin
                  flow_q <= flow_e'(mode_sel);
                  cnt_q  <= '0;
                  seen_q <= 1'b0;
                  st_q   <= (mode_sel == 2'(FLOW_OS)) ? ST_RUN : ST_LOAD;
               end
            end
            ST_LOAD: begin
               if (pre_vld) begin
                  if (cnt_q == CNT_W'(DIM - 1)) begin
                     cnt_q <= '0;
                     st_q  <= ST_RUN;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            ST_RUN: begin
               if (tick) begin
                  seen_q <= 1'b1;
                  if (cur_t == last_t) begin
                     cnt_q <= '0;
                     st_q  <= (flow_q == FLOW_OS) ? ST_DRAIN : ST_DONE;
                  end else begin
                     cnt_q <= cur_t + 1'b1;
                  end
               end
            end
            ST_DRAIN: begin
               if (cnt_q == CNT_W'(DIM - 1)) begin
                  cnt_q <= '0;
                  st_q  <= ST_DONE;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_DONE: st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign flow     = flow_q;
   assign clr      = accept;
   assign load_en  = (st_q == ST_LOAD) && pre_vld;
   assign run_en   = (st_q == ST_RUN);
   assign drain_en = (st_q == ST_DRAIN);
   assign done     = (st_q == ST_DONE);
   assign idle     = (st_q == ST_IDLE);

endmodule

// File: rtl/flexflow_grid.sv
module flexflow_grid
   import flexflow_pkg::*;
#(
   parameter int DIM    = 4,
   parameter int DATA_W = 8,
   parameter int ACC_W  = 32
) (
   input  logic                  clk,
   input  logic                  rst,
   input  flow_e                 flow,
   input  logic                  clr,
   input  logic                  load_en,
   input  logic                  run_en,
   input  logic                  drain_en,
   input  logic [DIM*DATA_W-1:0] pre_data,
   input  logic [DIM-1:0]        west_vld,
   input  logic [DIM*DATA_W-1:0] west_data,
   input  logic [DIM-1:0]        north_vld,
   input  logic [DIM*DATA_W-1:0] north_data,
   output logic [DIM-1:0]        res_vld,
   output logic [DIM*ACC_W-1:0]  res_data
);

   logic [DATA_W-1:0] h_w [DIM][DIM+1];
   logic              h_v [DIM][DIM+1];
   logic [DATA_W-1:0] v_w [DIM+1][DIM];
   logic              v_v [DIM+1][DIM];
   logic [DATA_W-1:0] s_w [DIM+1][DIM];
   logic [ACC_W-1:0]  p_w [DIM][DIM];
   logic              p_v [DIM][DIM];
   logic [ACC_W-1:0]  p_in [DIM][DIM];

   for (genvar n = 0; n < DIM; n++) begin : g_edge
      assign h_w[n][0] = west_data[n*DATA_W +: DATA_W];
      assign h_v[n][0] = west_vld[n] & run_en;
      assign v_w[0][n] = north_data[n*DATA_W +: DATA_W];
      assign v_v[0][n] = north_vld[n] & run_en;
      assign s_w[0][n] = pre_data[n*DATA_W +: DATA_W];
   end

   for (genvar r = 0; r < DIM; r++) begin : g_row
      for (genvar c = 0; c < DIM; c++) begin : g_col
         // partial sums run east in the weight flow, south otherwise
         if (r == 0 && c == 0) begin : g_corner
            assign p_in[r][c] = '0;
         end else if (r == 0) begin : g_top
            assign p_in[r][c] = (flow == FLOW_WS) ? p_w[r][c-1] : '0;
         end else if (c == 0) begin : g_left
            assign p_in[r][c] = (flow == FLOW_WS) ? '0 : p_w[r-1][c];
         end else begin : g_inner
            assign p_in[r][c] = (flow == FLOW_WS) ? p_w[r][c-1] : p_w[r-1][c];
         end

         flexflow_pe #(
            .DATA_W (DATA_W),
            .ACC_W  (ACC_W)
         ) i_pe (
            .clk        (clk),
            .rst        (rst),
            .flow       (flow),
            .clr        (clr),
            .load_en    (load_en),
            .drain_en   (drain_en),
            .h_in       (h_w[r][c]),
            .h_vld_in   (h_v[r][c]),
            .h_out      (h_w[r][c+1]),
            .h_vld_out  (h_v[r][c+1]),
            .v_in       (v_w[r][c]),
            .v_vld_in   (v_v[r][c]),
            .v_out      (v_w[r+1][c]),
            .v_vld_out  (v_v[r+1][c]),
            .stat_in    (s_w[r][c]),
            .stat_out   (s_w[r+1][c]),
            .ps_in      (p_in[r][c]),
            .ps_out     (p_w[r][c]),
            .ps_vld_out (p_v[r][c])
         );
      end
   end

   for (genvar l = 0; l < DIM; l++) begin : g_lane
      always_comb begin
         unique case (flow)
            FLOW_WS: begin
               res_data[l*ACC_W +: ACC_W] = p_w[l][DIM-1];
               res_vld[l]                 = p_v[l][DIM-1];
            end
            FLOW_IS: begin
               res_data[l*ACC_W +: ACC_W] = p_w[DIM-1][l];
               res_vld[l]                 = p_v[DIM-1][l];
            end
            default: begin
               res_data[l*ACC_W +: ACC_W] = p_w[DIM-1][l];
               res_vld[l]                 = drain_en;
            end
         endcase
      end
   end

endmodule

// File: rtl/flexflow_array.sv
module flexflow_array
   import flexflow_pkg::*;
#(
   parameter int DIM    = 4,
   parameter int DATA_W = 8,
   parameter int ACC_W  = 32
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  start,
   input  logic [1:0]            mode_sel,
   input  logic                  pre_vld,
   input  logic [DIM*DATA_W-1:0] pre_data,
   input  logic [DIM-1:0]        west_vld,
   input  logic [DIM*DATA_W-1:0] west_data,
   input  logic [DIM-1:0]        north_vld,
   input  logic [DIM*DATA_W-1:0] north_data,
   output logic [DIM-1:0]        res_vld,
   output logic [DIM*ACC_W-1:0]  res_data,
   output logic                  done
);

   if (DIM < 2) begin : g_bad_dim
      $error("flexflow_array: DIM must be at least 2");
   end
   if (ACC_W <= 2 * DATA_W) begin : g_bad_acc
      $error("flexflow_array: ACC_W must exceed the product width");
   end

   flow_e cfg_mode;
   logic  ctl_idle, clr, load_en, run_en, drain_en, any_vld;

   assign any_vld = (|west_vld) | (|north_vld);

   flexflow_ctl #(
      .DIM (DIM)
   ) i_ctl (
      .clk      (clk),
      .rst      (rst),
      .start    (start),
      .mode_sel (mode_sel),
      .pre_vld  (pre_vld),
      .any_vld  (any_vld),
      .flow     (cfg_mode),
      .clr      (clr),
      .load_en  (load_en),
      .run_en   (run_en),
      .drain_en (drain_en),
      .done     (done),
      .idle     (ctl_idle)
   );

   flexflow_grid #(
      .DIM    (DIM),
      .DATA_W (DATA_W),
      .ACC_W  (ACC_W)
   ) i_grid (
      .clk        (clk),
      .rst        (rst),
      .flow       (cfg_mode),
      .clr        (clr),
      .load_en    (load_en),
      .run_en     (run_en),
      .drain_en   (drain_en),
      .pre_data   (pre_data),
      .west_vld   (west_vld),
      .west_data  (west_data),
      .north_vld  (north_vld),
      .north_data (north_data),
      .res_vld    (res_vld),
      .res_data   (res_data)
   );

endmodule

// File: rtl/flexflow_chk.sv
module flexflow_chk #(
   parameter int DIM = 4
) (
   input logic           clk,
   input logic           rst,
   input logic           start,
   input logic [1:0]     mode_sel,
   input logic           done,
   input logic [DIM-1:0] res_vld,
   input logic           ctl_idle,
   input logic [1:0]     cfg_mode
);

   assert_reset_quiet_R1: assert property (@(posedge clk)
      rst |=> (res_vld == '0 && !done));

   assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   assert_drain_all_lanes_R4: assert property (@(posedge clk) disable iff (rst)
      (cfg_mode == 2'd2 && res_vld != '0) |-> (res_vld == '1));

   assert_mode_hold_R6: assert property (@(posedge clk) disable iff (rst)
      (!ctl_idle && !$past(ctl_idle)) |-> $stable(cfg_mode));

   assert_reserved_ignored_R7: assert property (@(posedge clk) disable iff (rst)
      (ctl_idle && start && mode_sel == 2'd3) |=> ctl_idle);

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
      ctl_idle |-> (res_vld == '0 && !done));

endmodule

bind flexflow_array flexflow_chk #(.DIM(DIM)) i_flexflow_chk (
   .clk      (clk),
   .rst      (rst),
   .start    (start),
   .mode_sel (mode_sel),
   .done     (done),
   .res_vld  (res_vld),
   .ctl_idle (ctl_idle),
   .cfg_mode (cfg_mode)
);

// File: tb/test_flexflow_array.sv
module test_flexflow_array;

   localparam int DIM        = 4;
   localparam int DW         = 8;
   localparam int AW         = 32;
   localparam int CLK_PERIOD = 10;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              start = 1'b0;
   logic [1:0]        mode_sel = '0;
   logic              pre_vld = 1'b0;
   logic [DIM*DW-1:0] pre_data = '0;
   logic [DIM-1:0]    west_vld = '0;
   logic [DIM*DW-1:0] west_data = '0;
   logic [DIM-1:0]    north_vld = '0;
   logic [DIM*DW-1:0] north_data = '0;
   logic [DIM-1:0]    res_vld;
   logic [DIM*AW-1:0] res_data;
   logic              done;

   int n_tests = 0;
   int n_fail  = 0;
   int mat_a [DIM][DIM];
   int mat_b [DIM][DIM];

   always #(CLK_PERIOD/2) clk = ~clk;

   flexflow_array #(.DIM(DIM), .DATA_W(DW), .ACC_W(AW)) i_flexflow_array (
      .clk(clk), .rst(rst), .start(start), .mode_sel(mode_sel),
      .pre_vld(pre_vld), .pre_data(pre_data),
      .west_vld(west_vld), .west_data(west_data),
      .north_vld(north_vld), .north_data(north_data),
      .res_vld(res_vld), .res_data(res_data), .done(done)
   );

   task automatic check(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int c_val(input int i, input int j);
      int s = 0;
      for (int k = 0; k < DIM; k++) s += mat_a[i][k] * mat_b[k][j];
      return s;
   endfunction

   task automatic fill_random();
      for (int i = 0; i < DIM; i++)
         for (int j = 0; j < DIM; j++) begin
            mat_a[i][j] = int'(byte'($urandom_range(0, 255)));
            mat_b[i][j] = int'(byte'($urandom_range(0, 255)));
         end
   endtask

   task automatic fill_const(input int a, input int b);
      for (int i = 0; i < DIM; i++)
         for (int j = 0; j < DIM; j++) begin
            mat_a[i][j] = a;
            mat_b[i][j] = b;
         end
   endtask

   task automatic quiet_check(input string req, input int cycles);
      for (int n = 0; n < cycles; n++) begin
         check(req, int'(res_vld), 0);
         check(req, int'(done), 0);
         @(negedge clk);
      end
   endtask

   // m: mode code, gap: idle cycles before first valid, inj_t: cycle of a stray start (-1 none)
   task automatic run_tile(input int m, input int gap, input int inj_t, input string extra);
      string rq;
      int    tdone;
      rq = (m == 0) ? "R2" : (m == 1) ? "R3" : "R4";
      rq = {rq, "/", extra};
      tdone = (m == 2) ? 4*DIM-2 : 3*DIM-1;
      @(negedge clk);
      start = 1'b1; mode_sel = 2'(m);
      @(negedge clk);
      start = 1'b0; mode_sel = 2'd0;
      if (m != 2) begin
         // R9: beat b, lane c feeds the cell in row DIM-1-b
         for (int b = 0; b < DIM; b++) begin
            pre_vld = 1'b1;
            for (int c = 0; c < DIM; c++)
               pre_data[c*DW +: DW] = DW'((m == 0) ? mat_b[c][DIM-1-b] : mat_a[c][DIM-1-b]);
            @(negedge clk);
         end
         pre_vld = 1'b0;
      end
      for (int g = 0; g < gap; g++) begin
         check({"R12/", rq}, int'(res_vld), 0);
         @(negedge clk);
      end
      for (int t = 0; t <= tdone; t++) begin
         logic [DIM-1:0] ev;
         for (int l = 0; l < DIM; l++) begin
            int idx, ex, d;
            idx = t - DIM - l;
            d   = t - (3*DIM-2);
            ev[l] = 1'b0;
            ex    = 0;
            if (m == 0 && idx >= 0 && idx < DIM) begin ev[l] = 1'b1; ex = c_val(idx, l); end
            if (m == 1 && idx >= 0 && idx < DIM) begin ev[l] = 1'b1; ex = c_val(l, idx); end
            if (m == 2 && d >= 0 && d < DIM)     begin ev[l] = 1'b1; ex = c_val(DIM-1-d, l); end
            if (ev[l])
               check(rq, int'($signed(res_data[l*AW +: AW])), ex);
         end
         check(rq, int'(res_vld), int'(ev));
         check({"R5/", rq}, int'(done), int'(t == tdone));
         // drive the skewed streams for cycle t
         for (int n = 0; n < DIM; n++) begin
            int k;
            k = t - n;
            west_vld[n]  = 1'b0;
            north_vld[n] = 1'b0;
            if (k >= 0 && k < DIM) begin
               if (m == 1) begin west_vld[n] = 1'b1; west_data[n*DW +: DW] = DW'(mat_b[n][k]); end
               if (m == 2) begin
                  west_vld[n]  = 1'b1; west_data[n*DW +: DW]  = DW'(mat_a[n][k]);
                  north_vld[n] = 1'b1; north_data[n*DW +: DW] = DW'(mat_b[k][n]);
               end
               if (m == 0) begin north_vld[n] = 1'b1; north_data[n*DW +: DW] = DW'(mat_a[k][n]); end
            end
         end
         start    = (t == inj_t);
         mode_sel = (t == inj_t) ? 2'((m + 1) % 3) : 2'd0;
         @(negedge clk);
      end
      start = 1'b0; mode_sel = 2'd0;
      west_vld = '0; north_vld = '0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int seed_dummy;
      seed_dummy = $urandom(32'd20240611);
      repeat (4) @(negedge clk);
      // R1: outputs quiet under reset
      check("R1", int'(res_vld), 0);
      check("R1", int'(done), 0);
      rst = 1'b0;
      @(negedge clk);
      check("R1", int'(res_vld), 0);
      check("R1", int'(done), 0);

      fill_random(); run_tile(0, 0, -1, "R9");
      fill_random(); run_tile(1, 0, -1, "R9");
      fill_random(); run_tile(2, 0, -1, "rand");
      // R11: output-stationary right after a weight-stationary tile
      fill_random(); run_tile(0, 0, -1, "rand");
      fill_random(); run_tile(2, 0, -1, "R11");
      // R10: stray valids while idle produce nothing
      west_vld = '1; north_vld = '1;
      quiet_check("R10", 2*DIM);
      west_vld = '0; north_vld = '0;
      // R12: idle cycles before the first valid
      fill_random(); run_tile(1, 3, -1, "R12");
      fill_random(); run_tile(2, 2, -1, "R12");
      // R6: start with another mode during a tile
      fill_random(); run_tile(0, 0, 2, "R6");
      fill_random(); run_tile(2, 0, 5, "R6");
      // R8: extreme signed operands
      fill_const(-128, -128); run_tile(2, 0, -1, "R8");
      fill_const(-128, 127);  run_tile(0, 0, -1, "R8");
      fill_const(127, -128);  run_tile(1, 0, -1, "R8");
      // R7: reserved mode code is ignored, next start accepted
      @(negedge clk);
      start = 1'b1; mode_sel = 2'd3;
      @(negedge clk);
      start = 1'b0; mode_sel = 2'd0;
      quiet_check("R7", 3);
      fill_random(); run_tile(0, 0, -1, "R7");
      // R13: reset in the middle of an output-stationary tile
      @(negedge clk);
      start = 1'b1; mode_sel = 2'd2;
      @(negedge clk);
      start = 1'b0;
      west_vld = '1; north_vld = '1;
      repeat (3) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0; west_vld = '0; north_vld = '0;
      quiet_check("R13", 2);
      fill_random(); run_tile(2, 0, -1, "R13");
      fill_random(); run_tile(1, 0, -1, "R13");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule